// File: doc/BRIEF.md
# Shared-Memory Bank Conflict Scheduler

This block takes one warp-wide shared-memory request and works out how it must be serialized on a memory of 32 banks, each one 4-byte word wide. A request carries 32 lane byte addresses, one enable bit per lane and one access size (4, 8 or 16 bytes per lane) that applies to the whole request. The scheduler cuts the request into transactions of at most 128 bytes. For each transaction it issues bank-access passes, one per clock. A pass never asks a bank for more than one distinct word.

Each pass carries three things: the lanes it serves, which banks it uses, and the row (word index within a bank) that each used bank must read. The pass also reports the transaction index and its own running number within that transaction. It flags the last pass of each transaction, so the running number on that pass is the conflict degree of the transaction. After the final pass, a one-cycle done pulse reports the total number of passes, which is the number of memory cycles the request costs. The memory array and the data return path sit outside this block.

Top module: `bank_conflict_sched`

## Requirements
- R1: A 4-byte word at byte address A lives in bank (A/4) mod 32 at row A/128. In every pass, `pass_bank_en` marks the banks in use and `pass_bank_row` gives each used bank its row in bits [9b+8:9b]. The row field of an unused bank is zero.
- R2: The size code selects how the request is split. Code 0 (4 bytes) is one transaction of all 32 lanes. Code 1 (8 bytes) is lanes 0-15, then lanes 16-31. Code 2 (16 bytes) is four transactions of 8 consecutive lanes. Code 3 behaves as code 2. Transactions are issued in ascending lane order, and `pass_xact` carries the index.
- R3: Within a transaction, each pass serves the lowest pending lane. It also serves every other pending lane whose words all land on banks that are free in that pass or already serving the same row. No lane is served twice.
- R4: The number of passes in a transaction equals its conflict degree: the largest count of distinct rows that its active lanes need from any one bank. `pass_num` counts 1, 2, … within the transaction, and `pass_last` marks the final pass.
- R5: Lanes that ask for the identical word share it and add nothing to the degree. If all lanes read one word, the request takes a single pass.
- R6: If consecutive lanes read consecutive 4-byte words, the request takes one pass. If lane k reads word 2k, it takes two passes: lanes 0-15, then lanes 16-31.
- R7: Inactive lanes never appear in a pass and do not affect the degree. A transaction with no active lanes issues no pass. A request with no active lanes issues no pass and reports zero passes.
- R8: An 8-byte lane covers words 2j and 2j+1, and a 16-byte lane covers words 4j to 4j+3, where j comes from the address with its low bits below the access size ignored. Every covered bank is marked in the pass with that lane's row.
- R9: `req_ready` is high only while no request is in flight, and a request is taken when `req_valid` and `req_ready` are both high. The first pass appears in the cycle after acceptance, and passes follow on consecutive cycles with no gaps.
- R10: `done` is high for exactly one cycle, the cycle after the final pass. For a request with no active lanes, that cycle comes two cycles after acceptance. `done_passes` holds the total pass count, and `req_ready` is high again in that same cycle.
- R11: While reset is held, and until the first request is accepted, `req_ready` is 1 and `pass_valid` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Scheduler idle, request can be taken |
| req_addr | input | LANES*ADDR_W | Byte address per lane, lane k in bits [k*ADDR_W +: ADDR_W] |
| req_active | input | LANES | Lane enables |
| req_size | input | 2 | Access size code: 0=4 B, 1=8 B, 2 or 3=16 B |
| pass_valid | output | 1 | A bank-access pass is issued this cycle |
| pass_lanes | output | LANES | Lanes served by this pass |
| pass_bank_en | output | BANKS | Banks used by this pass |
| pass_bank_row | output | BANKS*ROW_W | Row read by each bank in this pass |
| pass_xact | output | GRP_W | Transaction index of this pass |
| pass_num | output | CNT_W | Pass number within the transaction, from 1 |
| pass_last | output | 1 | Final pass of the transaction |
| done | output | 1 | One-cycle pulse after the final pass |
| done_passes | output | CNT_W | Total passes of the finished request |

## Verification
The bench goes after the cases that separate a per-transaction degree from a whole-request one. In the stride-2 pattern, a design that ignores the bank modulo would report one pass, and one that merges lanes 0 and 16 would report the wrong lane masks. The 8- and 16-byte requests check that multi-word lanes claim every covered bank. A design that failed to split transactions would mix lanes of different transactions in one pass or give a wrong `pass_xact`. The broadcast pattern catches a design that counts equal words twice. The 32-way pattern pushes `pass_num` and `done_passes` to their top value. The inactive-lane, empty-transaction and empty-request patterns catch designs that serve disabled lanes, issue an empty pass, or never raise `done`.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

  localparam int unsigned WORD_BYTES = 4;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } bcs_state_e;

  // size code 3 is treated as the 16-byte size
  function automatic logic [1:0] norm_size(input logic [1:0] code);
    return (code == 2'd3) ? 2'd2 : code;
  endfunction

  // number of 4-byte words one lane covers, as log2
  function automatic int unsigned words_log2(input logic [1:0] code);
    return int'(norm_size(code));
  endfunction

endpackage

// File: rtl/bcs_lane_map.sv
module bcs_lane_map
  import bcs_pkg::*;
#(
  parameter int LANES  = 32,
  parameter int ADDR_W = 16,
  parameter int BANK_W = 5,
  parameter int ROW_W  = 9,
  parameter int GRP_W  = 2,
  parameter int XSH    = 5
) (
  input  logic [LANES*ADDR_W-1:0] addr_flat,
  input  logic [1:0]              size,
  output logic [LANES*BANK_W-1:0] bank0_flat,
  output logic [LANES*ROW_W-1:0]  row_flat,
  output logic [LANES*GRP_W-1:0]  grp_flat
);
  localparam int WORD_W = ADDR_W - 2;

  logic [1:0]        sz;
  logic [WORD_W-1:0] align_mask;

  assign sz         = norm_size(size);
  assign align_mask = ~WORD_W'((32'd1 << words_log2(size)) - 32'd1);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [WORD_W-1:0] word;
    logic [WORD_W-1:0] base;
    logic              lo_unused;

    assign lo_unused = ^addr_flat[l*ADDR_W +: 2];
    assign word      = addr_flat[l*ADDR_W+2 +: WORD_W];
    assign base      = word & align_mask;

    assign bank0_flat[l*BANK_W +: BANK_W] = base[BANK_W-1:0];
    assign row_flat[l*ROW_W +: ROW_W]     = base[WORD_W-1:BANK_W];
    assign grp_flat[l*GRP_W +: GRP_W]     = GRP_W'(l >> (XSH - int'(sz)));
  end

endmodule

// File: rtl/bcs_pass_pick.sv
module bcs_pass_pick
  import bcs_pkg::*;
#(
  parameter int LANES  = 32,
  parameter int BANKS  = 32,
  parameter int BANK_W = 5,
  parameter int ROW_W  = 9,
  parameter int GRP_W  = 2
) (
  input  logic [LANES-1:0]        pending,
  input  logic [1:0]              size,
  input  logic [LANES*BANK_W-1:0] bank0_flat,
  input  logic [LANES*ROW_W-1:0]  row_flat,
  input  logic [LANES*GRP_W-1:0]  grp_flat,
  output logic [LANES-1:0]        win,
  output logic [LANES-1:0]        sel,
  output logic [BANKS-1:0]        bank_en,
  output logic [BANKS*ROW_W-1:0]  bank_row,
  output logic [GRP_W-1:0]        cur_grp
);
  logic [BANK_W-1:0] blk_mask;

  assign blk_mask = BANK_W'((32'd1 << words_log2(size)) - 32'd1);

  // the active transaction is the one holding the lowest pending lane
  always_comb begin
    cur_grp = '0;
    for (int l = LANES - 1; l >= 0; l--) begin
      if (pending[l]) cur_grp = grp_flat[l*GRP_W +: GRP_W];
    end
    for (int l = 0; l < LANES; l++) begin
      win[l] = pending[l] && (grp_flat[l*GRP_W +: GRP_W] == cur_grp);
    end
  end

  // each bank takes the row of the lowest window lane touching it
  always_comb begin
    bank_en  = '0;
    bank_row = '0;
    for (int b = 0; b < BANKS; b++) begin
      for (int l = LANES - 1; l >= 0; l--) begin
        if (win[l] && ((BANK_W'(b) & ~blk_mask) == bank0_flat[l*BANK_W +: BANK_W])) begin
          bank_en[b]                = 1'b1;
          bank_row[b*ROW_W +: ROW_W] = row_flat[l*ROW_W +: ROW_W];
        end
      end
    end
  end

  // a lane rides along when its block's chosen row is its own row
  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      sel[l] = win[l] &&
               (row_flat[l*ROW_W +: ROW_W] ==
                bank_row[int'(bank0_flat[l*BANK_W +: BANK_W])*ROW_W +: ROW_W]);
    end
  end

endmodule

// File: rtl/bank_conflict_sched.sv
module bank_conflict_sched
  import bcs_pkg::*;
#(
  parameter  int LANES      = 32,
  parameter  int BANKS      = 32,
  parameter  int ADDR_W     = 16,
  parameter  int XACT_BYTES = 128,
  localparam int BANK_W     = $clog2(BANKS),
  localparam int ROW_W      = ADDR_W - 2 - BANK_W,
  localparam int MAX_XACT   = LANES * 16 / XACT_BYTES,
  localparam int GRP_W      = (MAX_XACT > 1) ? $clog2(MAX_XACT) : 1,
  localparam int CNT_W      = $clog2(LANES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [LANES*ADDR_W-1:0] req_addr,
  input  logic [LANES-1:0]        req_active,
  input  logic [1:0]              req_size,
  output logic                    pass_valid,
  output logic [LANES-1:0]        pass_lanes,
  output logic [BANKS-1:0]        pass_bank_en,
  output logic [BANKS*ROW_W-1:0]  pass_bank_row,
  output logic [GRP_W-1:0]        pass_xact,
  output logic [CNT_W-1:0]        pass_num,
  output logic                    pass_last,
  output logic                    done,
  output logic [CNT_W-1:0]        done_passes
);
  localparam int XSH = $clog2(XACT_BYTES / WORD_BYTES);

  bcs_state_e              state_q;
  logic [LANES*ADDR_W-1:0] addr_q;
  logic [1:0]              size_q;
  logic [LANES-1:0]        pend_q;
  logic [CNT_W-1:0]        total_q;
  logic [CNT_W-1:0]        xpass_q;
  logic                    done_q;
  logic [CNT_W-1:0]        done_cnt_q;

  logic [LANES*BANK_W-1:0] bank0_flat;
  logic [LANES*ROW_W-1:0]  row_flat;
  logic [LANES*GRP_W-1:0]  grp_flat;
  logic [LANES-1:0]        win;
  logic [LANES-1:0]        sel;
  logic [BANKS-1:0]        bank_en;
  logic [BANKS*ROW_W-1:0]  bank_row;
  logic [GRP_W-1:0]        cur_grp;

  // named events for the checker
  logic             busy;
  logic             pass_fire;
  logic [LANES-1:0] rem;
  logic             xact_end;
  logic             finish;

  bcs_lane_map #(
    .LANES (LANES),
    .ADDR_W(ADDR_W),
    .BANK_W(BANK_W),
    .ROW_W (ROW_W),
    .GRP_W (GRP_W),
    .XSH   (XSH)
  ) u_map (
    .addr_flat (addr_q),
    .size      (size_q),
    .bank0_flat(bank0_flat),
    .row_flat  (row_flat),
    .grp_flat  (grp_flat)
  );

  bcs_pass_pick #(
    .LANES (LANES),
    .BANKS (BANKS),
    .BANK_W(BANK_W),
    .ROW_W (ROW_W),
    .GRP_W (GRP_W)
  ) u_pick (
    .pending   (pend_q),
    .size      (size_q),
    .bank0_flat(bank0_flat),
    .row_flat  (row_flat),
    .grp_flat  (grp_flat),
    .win       (win),
    .sel       (sel),
    .bank_en   (bank_en),
    .bank_row  (bank_row),
    .cur_grp   (cur_grp)
  );

  assign busy      = (state_q == ST_BUSY);
  assign pass_fire = busy && (|pend_q);
  assign rem       = pend_q & ~sel;
  assign xact_end  = pass_fire && ((rem & win) == '0);
  assign finish    = busy && (rem == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      addr_q     <= '0;
      size_q     <= '0;
      pend_q     <= '0;
      total_q    <= '0;
      xpass_q    <= '0;
      done_q     <= 1'b0;
      done_cnt_q <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            addr_q  <= req_addr;
            size_q  <= norm_size(req_size);
            pend_q  <= req_active;
            total_q <= '0;
            xpass_q <= '0;
            state_q <= ST_BUSY;
          end
        end
        ST_BUSY: begin
          if (pass_fire) begin
            pend_q  <= rem;
            total_q <= total_q + CNT_W'(1);
            xpass_q <= xact_end ? '0 : xpass_q + CNT_W'(1);
          end
          if (finish) begin
            state_q    <= ST_IDLE;
            done_q     <= 1'b1;
            done_cnt_q <= total_q + CNT_W'(pass_fire);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign pass_valid    = pass_fire;
  assign pass_lanes    = pass_fire ? sel : '0;
  assign pass_bank_en  = pass_fire ? bank_en : '0;
  assign pass_bank_row = pass_fire ? bank_row : '0;
  assign pass_xact     = cur_grp;
  assign pass_num      = xpass_q + CNT_W'(1);
  assign pass_last     = xact_end;
  assign done          = done_q;
  assign done_passes   = done_cnt_q;

endmodule

// File: rtl/bcs_checker.sv
module bcs_checker #(
  parameter int LANES = 32,
  parameter int BANKS = 32,
  parameter int GRP_W = 2,
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [LANES-1:0] req_active,
  input logic             pass_valid,
  input logic [LANES-1:0] pass_lanes,
  input logic [BANKS-1:0] pass_bank_en,
  input logic [GRP_W-1:0] pass_xact,
  input logic [CNT_W-1:0] pass_num,
  input logic             pass_last,
  input logic             done,
  input logic [LANES-1:0] rem_lanes
);
  logic [LANES-1:0] chk_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chk_act <= '0;
    else if (req_valid && req_ready) chk_act <= req_active;
  end

  AST_LANES_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    pass_valid |-> ((pass_lanes & ~chk_act) == '0) && (pass_lanes != '0)); // R7

  AST_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    pass_valid && $past(pass_valid) |-> ((pass_lanes & $past(pass_lanes)) == '0)); // R3

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    pass_valid |-> !req_ready); // R9

  AST_BANK_USED: assert property (@(posedge clk) disable iff (!rst_n)
    pass_valid |-> (pass_bank_en != '0)); // R1

  AST_NUM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    pass_valid && !pass_last |=> pass_valid && (pass_num == $past(pass_num) + CNT_W'(1))); // R4

  AST_SAME_XACT: assert property (@(posedge clk) disable iff (!rst_n)
    pass_valid && !pass_last |=> (pass_xact == $past(pass_xact))); // R2

  AST_XACT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    pass_valid && pass_last && (rem_lanes != '0) |=>
      pass_valid && (pass_xact > $past(pass_xact)) && (pass_num == CNT_W'(1))); // R2

  AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    pass_valid && (rem_lanes == '0) |=> done); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

endmodule

bind bank_conflict_sched bcs_checker #(
  .LANES(LANES),
  .BANKS(BANKS),
  .GRP_W(GRP_W),
  .CNT_W(CNT_W)
) u_bcs_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_active  (req_active),
  .pass_valid  (pass_valid),
  .pass_lanes  (pass_lanes),
  .pass_bank_en(pass_bank_en),
  .pass_xact   (pass_xact),
  .pass_num    (pass_num),
  .pass_last   (pass_last),
  .done        (done),
  .rem_lanes   (rem)
);

// File: tb/test_bank_conflict_sched.sv
`timescale 1ns/1ps
module test_bank_conflict_sched;
  localparam int LN = 32;
  localparam int AW = 16;
  localparam int RW = 9;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [LN*AW-1:0] req_addr = '0;
  logic [LN-1:0]    req_active = '0;
  logic [1:0]       req_size = '0;
  logic             pass_valid;
  logic [LN-1:0]    pass_lanes;
  logic [LN-1:0]    pass_bank_en;
  logic [LN*RW-1:0] pass_bank_row;
  logic [1:0]       pass_xact;
  logic [5:0]       pass_num;
  logic             pass_last;
  logic             done;
  logic [5:0]       done_passes;

  int total = 0;
  int bad = 0;

  int            t_addr [LN];
  logic [LN-1:0] t_act;
  int            t_size;

  typedef struct {
    logic [LN-1:0]    lanes;
    int               xact;
    int               num;
    bit               last;
    int               deg;
    logic [LN-1:0]    ben;
    logic [LN*RW-1:0] rows;
  } exp_t;
  exp_t exp_q[$];

  always #10 clk = ~clk;

  bank_conflict_sched i_bank_conflict_sched (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_addr     (req_addr),
    .req_active   (req_active),
    .req_size     (req_size),
    .pass_valid   (pass_valid),
    .pass_lanes   (pass_lanes),
    .pass_bank_en (pass_bank_en),
    .pass_bank_row(pass_bank_row),
    .pass_xact    (pass_xact),
    .pass_num     (pass_num),
    .pass_last    (pass_last),
    .done         (done),
    .done_passes  (done_passes)
  );

  task automatic check(input string tag, input logic [319:0] act, input logic [319:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // behavioural model: greedy lane walk per transaction, degree by distinct-row count
  task automatic build_model();
    int n;
    int per;
    exp_q.delete();
    n   = (t_size == 0) ? 1 : (t_size == 1) ? 2 : 4;
    per = LN / n;
    for (int t = 0; t < n; t++) begin
      bit left [LN];
      int deg;
      int num;
      deg = 0;
      for (int b = 0; b < LN; b++) begin
        int seen[$];
        seen.delete();
        for (int l = t * per; l < (t + 1) * per; l++) begin
          if (t_act[l]) begin
            int w;
            w = t_addr[l] / 4;
            w = w - (w % n);
            for (int k = 0; k < n; k++) begin
              if ((w + k) % 32 == b) begin
                bit dup;
                dup = 1'b0;
                foreach (seen[i]) if (seen[i] == (w + k) / 32) dup = 1'b1;
                if (!dup) seen.push_back((w + k) / 32);
              end
            end
          end
        end
        if (seen.size() > deg) deg = seen.size();
      end
      for (int l = 0; l < LN; l++) left[l] = t_act[l] && (l / per == t);
      num = 0;
      while (1) begin
        int   claim [LN];
        exp_t e;
        bit   any;
        any = 1'b0;
        foreach (left[i]) if (left[i]) any = 1'b1;
        if (!any) break;
        num++;
        foreach (claim[i]) claim[i] = -1;
        e.lanes = '0;
        for (int l = 0; l < LN; l++) begin
          if (left[l]) begin
            int w;
            bit ok;
            w  = t_addr[l] / 4;
            w  = w - (w % n);
            ok = 1'b1;
            for (int k = 0; k < n; k++)
              if (claim[(w + k) % 32] != -1 && claim[(w + k) % 32] != (w + k) / 32) ok = 1'b0;
            if (ok) begin
              for (int k = 0; k < n; k++) claim[(w + k) % 32] = (w + k) / 32;
              e.lanes[l] = 1'b1;
              left[l]    = 1'b0;
            end
          end
        end
        e.ben  = '0;
        e.rows = '0;
        for (int b = 0; b < LN; b++) begin
          if (claim[b] >= 0) begin
            e.ben[b]           = 1'b1;
            e.rows[b*RW +: RW] = RW'(claim[b]);
          end
        end
        e.xact = t;
        e.num  = num;
        e.deg  = deg;
        e.last = 1'b1;
        foreach (left[i]) if (left[i]) e.last = 1'b0;
        exp_q.push_back(e);
      end
    end
  endtask

  task automatic run_req(input string nm);
    build_model();
    @(negedge clk);
    check({nm, " R9 ready when idle"}, req_ready, 1);
    for (int l = 0; l < LN; l++) req_addr[l*AW +: AW] = AW'(t_addr[l]);
    req_active = t_act;
    req_size   = 2'(t_size);
    req_valid  = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (exp_q.size() == 0) begin
      check({nm, " R7 no pass"}, pass_valid, 0);
      @(negedge clk);
    end
    foreach (exp_q[i]) begin
      check({nm, " R9 pass valid"}, pass_valid, 1);
      check({nm, " R9 busy not ready"}, req_ready, 0);
      check({nm, " R3 lanes"}, pass_lanes, exp_q[i].lanes);
      check({nm, " R2 xact"}, pass_xact, 320'(exp_q[i].xact));
      check({nm, " R4 num"}, pass_num, 320'(exp_q[i].num));
      check({nm, " R4 last"}, pass_last, 320'(exp_q[i].last));
      check({nm, " R1 banks"}, pass_bank_en, exp_q[i].ben);
      check({nm, " R8 rows"}, pass_bank_row, exp_q[i].rows);
      if (exp_q[i].last) check({nm, " R4 degree"}, pass_num, 320'(exp_q[i].deg));
      @(negedge clk);
    end
    check({nm, " R10 done"}, done, 1);
    check({nm, " R10 count"}, done_passes, 320'(exp_q.size()));
    check({nm, " R10 ready"}, req_ready, 1);
    check({nm, " R10 quiet"}, pass_valid, 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check("R11 reset ready", req_ready, 1);
    check("R11 reset valid", pass_valid, 0);
    check("R11 reset done", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 idle ready", req_ready, 1);
    check("R11 idle valid", pass_valid, 0);
    check("R11 idle done", done, 0);

    t_size = 0; t_act = '1;
    for (int l = 0; l < LN; l++) t_addr[l] = 4 * l;
    run_req("R6 consecutive");

    for (int l = 0; l < LN; l++) t_addr[l] = 8 * l;
    run_req("R6 stride2");

    for (int l = 0; l < LN; l++) t_addr[l] = 40;
    run_req("R5 broadcast");

    for (int l = 0; l < LN; l++) t_addr[l] = (l % 2 == 0) ? 4 * l : 4 * l + 128;
    run_req("R5 mixed rows");

    for (int l = 0; l < LN; l++) t_addr[l] = 128 * l;
    run_req("R4 worst case");

    t_act = 32'h0000_FFFF;
    for (int l = 0; l < LN; l++) t_addr[l] = 8 * l;
    run_req("R7 inactive lanes");

    t_act = '0;
    run_req("R7 empty request");

    t_size = 1; t_act = '1;
    for (int l = 0; l < LN; l++) t_addr[l] = 8 * l;
    run_req("R2 eight byte");

    for (int l = 0; l < LN; l++) t_addr[l] = 8 * l + 4;
    run_req("R8 low bits ignored");

    t_act = 32'hFFFF_0000;
    run_req("R7 empty first transaction");

    t_size = 2; t_act = '1;
    for (int l = 0; l < LN; l++) t_addr[l] = 16 * l;
    run_req("R2 sixteen byte");

    for (int l = 0; l < LN; l++) t_addr[l] = 32 * l;
    run_req("R8 sixteen byte stride");

    t_size = 3;
    for (int l = 0; l < LN; l++) t_addr[l] = 16 * l;
    run_req("R2 size code three");

    for (int k = 0; k < 12; k++) begin
      t_size = k % 3;
      t_act  = $urandom;
      for (int l = 0; l < LN; l++) t_addr[l] = int'($urandom % 768);
      run_req("R4 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule